// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block schedules read requests for a single DRAM bank. Requests arrive one per cycle, each carrying a small application number and the row it targets. They wait in a queue that is kept in arrival order. Whenever the bank is free, one queued request is chosen and served with the command sequence its row state needs. A row hit needs a single read. The very first access after reset needs an activate and then a read. Any other miss needs a precharge, then an activate, then a read. Each command takes one controller cycle, so a hit costs one cycle, the first miss costs two and every later miss costs three.

A mode input chooses the selection rule. In arrival-order mode the oldest request is always served next. In locality mode a queued request that targets the currently open row is served before older requests that miss, and the oldest of the hits wins. A per-application timestamp records the cycle at which that application's most recent request finished. Because requests of one application always finish in increasing time, this value is the application's stall time once its queue drains. A one-cycle completion pulse reports the application and hit status of each finished request.

Top module: `rowhit_sched`

## Requirements
- R1: After reset the queue is empty, no row is open, every stall timestamp is zero, `cmd` is idle (0), `done_valid` is low and `req_ready` is high.
- R2: When no row is open, the first request chosen issues ACTIVATE in the cycle after it is selected and READ in the following cycle. Its completion timestamp is the acceptance edge count plus 3.
- R3: A request to the open row issues only READ in the cycle after selection, with `done_hit` high. Its completion timestamp is the acceptance edge count plus 2 when the bank was idle.
- R4: A request to a row other than the open row issues PRECHARGE, ACTIVATE and READ in three consecutive cycles. The `cmd` encoding is 0 idle, 1 precharge, 2 activate, 3 read.
- R5: With `mode_hit_first` low, requests are served strictly in arrival order, even when a younger request hits the open row.
- R6: With `mode_hit_first` high, a queued request to the open row is served before any older request that misses.
- R7: With `mode_hit_first` high and several queued hits, the oldest hit is served first.
- R8: Slice a of `stall_time` (bits a*TIME_W and up) holds the number of clock edges since reset at the end of the READ of application a's latest request. Slices of other applications are unchanged.
- R9: `req_ready` is low exactly when 8 requests are queued. A request offered while `req_ready` is low is dropped and never served.
- R10: `done_valid` is high for exactly one cycle per served request, in that request's READ cycle, with `done_app` and `done_hit` describing it. The next selection happens on the edge that ends this READ, leaving no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one cycle per command slot |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_hit_first | input | 1 | 1: open-row hits first, then oldest; 0: oldest first |
| req_valid | input | 1 | Offer of a new request this cycle |
| req_app | input | 2 | Application number of the offered request |
| req_row | input | 2 | Target row of the offered request |
| req_ready | output | 1 | Queue has room; an offer is accepted only when high |
| cmd | output | 2 | Command in this cycle: 0 idle, 1 precharge, 2 activate, 3 read |
| done_valid | output | 1 | A request completes at the end of this cycle |
| done_app | output | 2 | Application of the completing request |
| done_hit | output | 1 | The completing request was a row hit |
| open_valid | output | 1 | A row is open in the bank |
| open_row | output | 2 | Currently open row |
| stall_time | output | 64 | Four 16-bit completion timestamps, application 0 in the low bits |

## Verification
The assertions take for granted that the request inputs carry known values whenever `req_valid` is high, and that `mode_hit_first` is only relevant on selection edges. The assertions also assume that a timestamp does not wrap within a run, since the stall check compares against the edge count plus one. The stimulus changes every input only on falling edges. It switches the mode only while the queue is empty and the bank is idle, and all of its runs are far shorter than the 16-bit timestamp range. In the overflow scenario, requests keep being offered while the queue is full. This checks that such offers neither disturb the queued entries nor get served.

// File: rtl/rowhit_pkg.sv
package rowhit_pkg;
  localparam int APP_W    = 2;
  localparam int ROW_W    = 2;
  localparam int NUM_APPS = 1 << APP_W;

  // service costs in controller cycles
  localparam int HIT_CYC  = 1;
  localparam int OPEN_CYC = 2;
  localparam int MISS_CYC = 3;
  localparam int CYC_W    = $clog2(MISS_CYC + 1);

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_PRE = 2'd1,
    CMD_ACT = 2'd2,
    CMD_RD  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic             vld;
    logic [APP_W-1:0] app;
    logic [ROW_W-1:0] row;
  } req_t;

  // cycles needed to serve a request given the bank state
  function automatic logic [CYC_W-1:0] service_cycles(input logic row_open,
                                                      input logic row_hit);
    if (row_hit)       return CYC_W'(HIT_CYC);
    else if (!row_open) return CYC_W'(OPEN_CYC);
    else               return CYC_W'(MISS_CYC);
  endfunction

  // the command depends only on how many cycles of the access remain
  function automatic cmd_e phase_cmd(input logic [CYC_W-1:0] left);
    case (left)
      CYC_W'(3): return CMD_PRE;
      CYC_W'(2): return CMD_ACT;
      CYC_W'(1): return CMD_RD;
      default:   return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/rhs_req_queue.sv
module rhs_req_queue
  import rowhit_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  req_t          enq_ent,
  input  logic          deq,
  input  logic [IW-1:0] deq_idx,
  output req_t          ents [DEPTH],
  output logic [CW-1:0] count
);
  req_t          q  [DEPTH];
  req_t          nq [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] base;

  // entries above the removed one slide down, so index 0 stays oldest
  always_comb begin
    base = cnt_q - CW'(deq);
    for (int i = 0; i < DEPTH; i++) begin
      if (deq && (IW'(i) >= deq_idx)) begin
        nq[i] = (i + 1 < DEPTH) ? q[(i + 1 < DEPTH) ? (i + 1) : i] : '0;
      end else begin
        nq[i] = q[i];
      end
      if (enq && (CW'(i) == base)) begin
        nq[i]     = enq_ent;
        nq[i].vld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt_q <= base + CW'(enq);
      for (int i = 0; i < DEPTH; i++) q[i] <= nq[i];
    end
  end

  assign ents  = q;
  assign count = cnt_q;
endmodule

// File: rtl/rhs_pick.sv
module rhs_pick
  import rowhit_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IW    = $clog2(DEPTH)
) (
  input  req_t             ents [DEPTH],
  input  logic             mode_hit_first,
  input  logic             open_valid,
  input  logic [ROW_W-1:0] open_row,
  output logic             found,
  output logic [IW-1:0]    idx,
  output logic             hit,
  output logic             any_hit
);
  logic          found_any;
  logic [IW-1:0] old_idx;
  logic [IW-1:0] hit_idx;

  always_comb begin
    found_any = 1'b0;
    any_hit   = 1'b0;
    old_idx   = '0;
    hit_idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ents[i].vld) begin
        if (!found_any) begin
          found_any = 1'b1;
          old_idx   = IW'(i);
        end
        if (open_valid && (ents[i].row == open_row) && !any_hit) begin
          any_hit = 1'b1;
          hit_idx = IW'(i);
        end
      end
    end
    found = found_any;
    idx   = (mode_hit_first && any_hit) ? hit_idx : old_idx;
    hit   = found_any && open_valid && (ents[idx].row == open_row);
  end
endmodule

// File: rtl/rhs_bank_timer.sv
module rhs_bank_timer
  import rowhit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [APP_W-1:0] fire_app,
  input  logic [ROW_W-1:0] fire_row,
  input  logic             fire_hit,
  output cmd_e             cmd,
  output logic             can_fire,
  output logic             last_cycle,
  output logic             open_valid,
  output logic [ROW_W-1:0] open_row,
  output logic [APP_W-1:0] cur_app,
  output logic             cur_hit
);
  logic [CYC_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q     <= '0;
      open_valid <= 1'b0;
      open_row   <= '0;
      cur_app    <= '0;
      cur_hit    <= 1'b0;
    end else if (fire) begin
      left_q     <= service_cycles(open_valid, fire_hit);
      open_valid <= 1'b1;
      open_row   <= fire_row;
      cur_app    <= fire_app;
      cur_hit    <= fire_hit;
    end else if (left_q != '0) begin
      left_q <= left_q - CYC_W'(1);
    end
  end

  assign cmd        = phase_cmd(left_q);
  assign last_cycle = (left_q == CYC_W'(1));
  assign can_fire   = (left_q <= CYC_W'(1));
endmodule

// File: rtl/rhs_stall_log.sv
module rhs_stall_log
  import rowhit_pkg::*;
#(
  parameter int TIME_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       done,
  input  logic [APP_W-1:0]           done_app,
  output logic [TIME_W-1:0]          now,
  output logic [NUM_APPS*TIME_W-1:0] stall_flat
);
  always_ff @(posedge clk) begin
    if (!rst_n) now <= '0;
    else        now <= now + TIME_W'(1);
  end

  for (genvar a = 0; a < NUM_APPS; a++) begin : g_app
    logic [TIME_W-1:0] stamp_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                stamp_q <= '0;
      else if (done && (done_app == APP_W'(a)))  stamp_q <= now + TIME_W'(1);
    end
    assign stall_flat[a*TIME_W +: TIME_W] = stamp_q;
  end
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
  import rowhit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_hit_first,
  input  logic                       req_valid,
  input  logic [APP_W-1:0]           req_app,
  input  logic [ROW_W-1:0]           req_row,
  output logic                       req_ready,
  output logic [1:0]                 cmd,
  output logic                       done_valid,
  output logic [APP_W-1:0]           done_app,
  output logic                       done_hit,
  output logic                       open_valid,
  output logic [ROW_W-1:0]           open_row,
  output logic [NUM_APPS*TIME_W-1:0] stall_time
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  req_t              q_ents [DEPTH];
  req_t              enq_ent;
  logic [CW-1:0]     q_count;
  logic              enq;
  logic              fire;
  logic              sel_found;
  logic [IW-1:0]     sel_idx;
  logic              sel_hit;
  logic              sel_any_hit;
  logic              can_fire;
  logic              last_cycle;
  cmd_e              bank_cmd;
  logic [TIME_W-1:0] now;

  assign req_ready = (q_count < CW'(DEPTH));
  assign enq       = req_valid && req_ready;
  assign enq_ent   = '{vld: 1'b1, app: req_app, row: req_row};
  assign fire      = can_fire && sel_found;

  rhs_req_queue #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_queue (
    .clk, .rst_n, .enq, .enq_ent,
    .deq(fire), .deq_idx(sel_idx), .ents(q_ents), .count(q_count)
  );

  rhs_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
    .ents(q_ents), .mode_hit_first, .open_valid, .open_row,
    .found(sel_found), .idx(sel_idx), .hit(sel_hit), .any_hit(sel_any_hit)
  );

  rhs_bank_timer u_timer (
    .clk, .rst_n, .fire,
    .fire_app(q_ents[sel_idx].app), .fire_row(q_ents[sel_idx].row),
    .fire_hit(sel_hit), .cmd(bank_cmd), .can_fire, .last_cycle,
    .open_valid, .open_row, .cur_app(done_app), .cur_hit(done_hit)
  );

  assign done_valid = last_cycle;
  assign cmd        = bank_cmd;

  rhs_stall_log #(.TIME_W(TIME_W)) u_stall (
    .clk, .rst_n, .done(done_valid), .done_app, .now, .stall_flat(stall_time)
  );
endmodule

// File: rtl/rowhit_sched_chk.sv
module rowhit_sched_chk
  import rowhit_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 16,
  parameter int IW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mode_hit_first,
  input logic                       req_ready,
  input logic [1:0]                 cmd,
  input logic                       done_valid,
  input logic [APP_W-1:0]           done_app,
  input logic                       done_hit,
  input logic [CW-1:0]              q_count,
  input logic                       fire,
  input logic [IW-1:0]              sel_idx,
  input logic                       sel_hit,
  input logic                       sel_any_hit,
  input logic [TIME_W-1:0]          now,
  input logic [NUM_APPS*TIME_W-1:0] stall_time
);
  assert_act_then_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> (cmd == CMD_RD));

  assert_hit_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_hit) |-> ($past(cmd) != CMD_ACT));

  assert_pre_then_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |=> (cmd == CMD_ACT));

  assert_miss_had_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_hit) |-> ($past(cmd) == CMD_ACT));

  assert_oldest_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mode_hit_first) |-> (sel_idx == '0));

  assert_hit_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_hit_first && sel_any_hit) |-> sel_hit);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  assert_ready_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (q_count == CW'(DEPTH)));

  assert_done_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (cmd == CMD_RD));

  for (genvar a = 0; a < NUM_APPS; a++) begin : g_stamp
    assert_stamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && (done_app == APP_W'(a))) |=>
        (stall_time[a*TIME_W +: TIME_W] == $past(now) + TIME_W'(1)));
  end
endmodule

bind rowhit_sched rowhit_sched_chk #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_hit_first(mode_hit_first),
  .req_ready(req_ready), .cmd(cmd), .done_valid(done_valid),
  .done_app(done_app), .done_hit(done_hit), .q_count(q_count),
  .fire(fire), .sel_idx(sel_idx), .sel_hit(sel_hit),
  .sel_any_hit(sel_any_hit), .now(now), .stall_time(stall_time)
);

// File: tb/rowhit_sched_test.sv
`timescale 1ns/1ps
module rowhit_sched_test;
  import rowhit_pkg::*;
  localparam int TW = 16;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0, req_valid = 1'b0;
  logic [1:0] req_app = '0, req_row = '0;
  logic req_ready, done_valid, done_hit, open_valid;
  logic [1:0] cmd, done_app, open_row;
  logic [4*TW-1:0] stall_time;

  rowhit_sched uut (
    .clk, .rst_n, .mode_hit_first(mode), .req_valid, .req_app, .req_row,
    .req_ready, .cmd, .done_valid, .done_app, .done_hit, .open_valid,
    .open_row, .stall_time
  );

  always #4 clk = ~clk;

  int t = 0;
  always @(posedge clk) if (!rst_n) t <= 0; else t <= t + 1;

  int dn = 0;
  always @(negedge clk) if (rst_n && done_valid) dn <= dn + 1;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stall_of(int a);
    return int'(stall_time[a*TW +: TW]);
  endfunction

  task automatic push(int a, int r);
    req_valid = 1'b1;
    req_app   = 2'(a);
    req_row   = 2'(r);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic test_reset;
    chk("R1 cmd", int'(cmd), 0);
    chk("R1 done_valid", int'(done_valid), 0);
    chk("R1 open_valid", int'(open_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    for (int a = 0; a < 4; a++) chk("R1 stall", stall_of(a), 0);
  endtask

  int s1;
  task automatic test_first_miss;
    int a0;
    push(1, 2); a0 = t; req_valid = 1'b0;
    step(1);
    chk("R2 activate", int'(cmd), 2);
    chk("R2 open_row", int'(open_row), 2);
    step(1);
    chk("R2 read", int'(cmd), 3);
    chk("R10 done app", int'(done_valid) * 10 + int'(done_app), 11);
    chk("R10 done miss", int'(done_hit), 0);
    step(1);
    chk("R2 stall", stall_of(1), a0 + 3);
    chk("R10 single pulse", int'(done_valid), 0);
    s1 = stall_of(1);
  endtask

  task automatic test_hit;
    int b0;
    push(2, 2); b0 = t; req_valid = 1'b0;
    step(1);
    chk("R3 read only", int'(cmd), 3);
    chk("R3 done hit", int'(done_valid) * 10 + int'(done_hit), 11);
    step(1);
    chk("R3 stall", stall_of(2), b0 + 2);
    chk("R8 other app held", stall_of(1), s1);
    chk("R3 idle after", int'(cmd), 0);
  endtask

  task automatic test_miss;
    int c0;
    push(3, 0); c0 = t; req_valid = 1'b0;
    step(1); chk("R4 precharge", int'(cmd), 1);
    step(1); chk("R4 activate", int'(cmd), 2);
    step(1); chk("R4 read", int'(cmd), 3);
    chk("R4 done miss", int'(done_valid) * 10 + int'(done_hit), 10);
    step(1);
    chk("R4 stall", stall_of(3), c0 + 4);
    chk("R4 open_row", int'(open_row), 0);
  endtask

  task automatic test_hit_first;
    int d0;
    mode = 1'b1; step(2);
    push(0, 1); d0 = t;
    push(1, 3); push(2, 1); push(3, 1); req_valid = 1'b0;
    chk("R10 first done app0", int'(done_valid) * 10 + int'(done_app), 10);
    step(1);
    chk("R6 hit jumps ahead", int'(done_app), 2);
    chk("R6 hit flag", int'(done_hit), 1);
    step(1);
    chk("R7 oldest hit next", int'(done_app), 3);
    step(3);
    chk("R6 miss served last", int'(done_valid) * 10 + int'(done_app), 11);
    step(1);
    chk("R8 stall a0", stall_of(0), d0 + 4);
    chk("R8 stall a1", stall_of(1), d0 + 9);
    chk("R8 stall a2", stall_of(2), d0 + 5);
    chk("R8 stall a3", stall_of(3), d0 + 6);
  endtask

  task automatic test_oldest;
    int d0;
    mode = 1'b0; step(2);
    push(0, 2); d0 = t;
    push(1, 3); push(2, 2); push(3, 2); req_valid = 1'b0;
    chk("R5 first done", int'(done_app), 0);
    step(3);
    chk("R5 older miss first", int'(done_valid) * 10 + int'(done_app), 11);
    step(3);
    chk("R5 then app2 miss", int'(done_app) * 10 + int'(done_hit), 20);
    step(1);
    chk("R5 then app3 hit", int'(done_app) * 10 + int'(done_hit), 31);
    step(1);
    chk("R8 stall a0", stall_of(0), d0 + 4);
    chk("R8 stall a1", stall_of(1), d0 + 7);
    chk("R8 stall a2", stall_of(2), d0 + 10);
    chk("R8 stall a3", stall_of(3), d0 + 11);
  endtask

  task automatic test_full;
    int acc = 0, low = 0, dn0;
    mode = 1'b0; step(2);
    dn0 = dn;
    for (int i = 0; i < 20; i++) begin
      req_valid = 1'b1;
      req_app   = 2'(i % 4);
      req_row   = 2'(i % 2);
      if (req_ready) acc++; else low = 1;
      step(1);
    end
    req_valid = 1'b0;
    chk("R9 ready dropped when full", low, 1);
    step(40);
    chk("R9 dropped offers not served", dn - dn0, acc);
    chk("R9 ready after drain", int'(req_ready), 1);
  endtask

  initial begin
    step(2);
    test_reset;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_first_miss;
    test_hit;
    test_miss;
    test_hit_first;
    test_oldest;
    test_full;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule